// File: doc/BRIEF.md
# Configuration Lock and Signature Access Controller

This block sits in front of the configuration store of a programmable logic array. It accepts one command per clock and answers each one a cycle later with a status code and, for reads, a data word. The commands write or read back configuration words, force individual macrocell registers to a chosen level, write or read an eight-byte user signature, set a one-time lock, and perform a full erase. The configuration words, the signature bytes, the preload register bits and the lock flag are all held as flip-flops inside the block.

The lock takes effect on the cycle after the command that sets it. From then on it refuses readback, preload and configuration writes, and a readback returns zero data. The lock survives every command except a full erase. A full erase clears the lock and every configuration word. The signature is not protected by the lock: it can be written and read in either lock state.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset the lock is clear, every preload bit is 0, no response is pending, and reading back any configuration address returns 0.
- R2: Each cycle with `cmd_valid` high produces `rsp_valid` high on the next cycle, and `rsp_valid` is low otherwise. Opcodes are: 0 no-op, 1 program, 2 verify, 3 preload, 4 signature write, 5 signature read, 6 set lock, 7 full erase. Status codes are: 0 ok, 1 locked, 2 bad address. Any command that does not read returns data 0, and a no-op returns status 0.
- R3: While the lock is clear, a program writes an 8-bit word to configuration address 0..31, and a verify at that address returns the word with status 0.
- R4: An address outside the target range returns status 2 and changes nothing. The ranges are 0..31 for configuration, 0..9 for preload and 0..7 for signature. Read data is 0 in that case.
- R5: While the lock is clear, a preload at address k sets bit k of `preload_q` to `cmd_wdata[0]` and leaves the other bits as they were.
- R6: A signature write or read at byte 0..7 works with status 0 whether or not the lock is set.
- R7: A set-lock command returns status 0 and raises `locked`, and the very next command already sees the lock. `locked` stays high until a full erase.
- R8: While locked, a verify at any address returns status 1 with data 0.
- R9: While locked, a preload returns status 1 and `preload_q` keeps its value.
- R10: While locked, a program returns status 1 and writes nothing. Programming works again after a full erase.
- R11: A full erase returns status 0, clears the lock and sets every configuration word to 0. It leaves the signature bytes and `preload_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 6 | Word, bit or byte address |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | Status of the previous command |
| rsp_rdata | output | 8 | Read data of the previous command |
| locked | output | 1 | Lock flag |
| preload_q | output | 10 | Macrocell register values |

## Verification
Every result of this block is due exactly one clock after the command that causes it. This applies to the status, the read data, the lock flag and the preload bits. Each bench task drives a command on a falling edge, lets one rising edge capture it, and reads every output at the next falling edge, before the following command is driven. A readback therefore always reflects the storage as it stood before a write in the same cycle. The cycle after an idle edge is also checked to confirm that no response appears.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_VERIFY  = 3'd2,
    OP_PRELOAD = 3'd3,
    OP_SIG_WR  = 3'd4,
    OP_SIG_RD  = 3'd5,
    OP_LOCK    = 3'd6,
    OP_ERASE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_LOCKED  = 2'd1,
    ST_BADADDR = 2'd2
  } st_e;

  localparam int unsigned SIG_BYTES = 8;

  // Range rule shared by every address decode.
  function automatic logic addr_ok(input int unsigned addr, input int unsigned limit);
    return addr < limit;
  endfunction

endpackage

// File: rtl/cfgsec_store.sv
module cfgsec_store #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cfgsec_decode.sv
module cfgsec_decode
  import cfgsec_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CFG_DEPTH = 32,
  parameter int NUM_REG   = 10
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              locked,
  output logic              cfg_we,
  output logic              cfg_rd,
  output logic              pre_we,
  output logic              sig_we,
  output logic              sig_rd,
  output logic              lock_set,
  output logic              erase,
  output logic              deny,
  output st_e               status
);
  int unsigned a;
  assign a = 32'(cmd_addr);

  always_comb begin
    cfg_we = 1'b0; cfg_rd = 1'b0; pre_we = 1'b0;
    sig_we = 1'b0; sig_rd = 1'b0; lock_set = 1'b0;
    erase = 1'b0; deny = 1'b0; status = ST_OK;
    if (cmd_valid) begin
      case (op_e'(cmd_op))
        OP_PROG, OP_VERIFY, OP_PRELOAD: begin
          // Lock is checked before the address range.
          if (locked) begin
            deny = 1'b1;
            status = ST_LOCKED;
          end else if (!addr_ok(a, (op_e'(cmd_op) == OP_PRELOAD) ? NUM_REG : CFG_DEPTH)) begin
            status = ST_BADADDR;
          end else begin
            cfg_we = (op_e'(cmd_op) == OP_PROG);
            cfg_rd = (op_e'(cmd_op) == OP_VERIFY);
            pre_we = (op_e'(cmd_op) == OP_PRELOAD);
          end
        end
        OP_SIG_WR, OP_SIG_RD: begin
          if (!addr_ok(a, SIG_BYTES)) status = ST_BADADDR;
          else begin
            sig_we = (op_e'(cmd_op) == OP_SIG_WR);
            sig_rd = (op_e'(cmd_op) == OP_SIG_RD);
          end
        end
        OP_LOCK:  lock_set = 1'b1;
        OP_ERASE: erase = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgsec_preload.sv
module cfgsec_preload #(
  parameter int ADDR_W  = 6,
  parameter int NUM_REG = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  idx,
  input  logic               d,
  output logic [NUM_REG-1:0] q
);
  for (genvar i = 0; i < NUM_REG; i++) begin : g_bit
    logic hit;
    assign hit = we && (32'(idx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (hit) q[i] <= d;
    end
  end
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
  import cfgsec_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int CFG_DEPTH = 32,
  parameter int NUM_REG   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               locked,
  output logic [NUM_REG-1:0] preload_q
);
  localparam int CFG_IW = $clog2(CFG_DEPTH);
  localparam int SIG_IW = $clog2(SIG_BYTES);

  // Named internal events, also used by the checker.
  logic ev_cfg_write, ev_cfg_read, ev_pre_write, ev_sig_write, ev_sig_read;
  logic ev_lock_set, ev_erase, ev_deny;
  st_e  dec_status;
  logic [DATA_W-1:0] cfg_rdata, sig_rdata;

  cfgsec_decode #(.ADDR_W(ADDR_W), .CFG_DEPTH(CFG_DEPTH), .NUM_REG(NUM_REG)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .locked(locked),
    .cfg_we(ev_cfg_write), .cfg_rd(ev_cfg_read), .pre_we(ev_pre_write),
    .sig_we(ev_sig_write), .sig_rd(ev_sig_read), .lock_set(ev_lock_set),
    .erase(ev_erase), .deny(ev_deny), .status(dec_status)
  );

  cfgsec_store #(.W(DATA_W), .DEPTH(CFG_DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(ev_erase), .we(ev_cfg_write),
    .waddr(cmd_addr[CFG_IW-1:0]), .wdata(cmd_wdata),
    .raddr(cmd_addr[CFG_IW-1:0]), .rdata(cfg_rdata)
  );

  cfgsec_store #(.W(DATA_W), .DEPTH(SIG_BYTES)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .we(ev_sig_write),
    .waddr(cmd_addr[SIG_IW-1:0]), .wdata(cmd_wdata),
    .raddr(cmd_addr[SIG_IW-1:0]), .rdata(sig_rdata)
  );

  cfgsec_preload #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_pre (
    .clk(clk), .rst_n(rst_n), .we(ev_pre_write), .idx(cmd_addr),
    .d(cmd_wdata[0]), .q(preload_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked <= 1'b0;
    else if (ev_erase)    locked <= 1'b0;
    else if (ev_lock_set) locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_status <= dec_status;
      rsp_rdata  <= ev_cfg_read ? cfg_rdata : (ev_sig_read ? sig_rdata : '0);
    end
  end
endmodule

// File: rtl/cfgsec_checker.sv
module cfgsec_checker #(
  parameter int NUM_REG = 10,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic               locked,
  input logic               rsp_valid,
  input logic [1:0]         rsp_status,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_REG-1:0] preload_q,
  input logic               ev_cfg_write,
  input logic               ev_deny
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status != 2'd3);
  assert_sig_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> rsp_status != 2'd1);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(cmd_valid && cmd_op == 3'd7)) |=> locked);
  assert_deny_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && locked) |=> (rsp_status == 2'd1 && rsp_rdata == '0));
  assert_preload_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(preload_q));
  assert_no_locked_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !ev_cfg_write);
  assert_deny_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deny |-> locked);
  assert_erase_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7) |=> !locked);
endmodule

bind cfgsec_ctrl cfgsec_checker #(.NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .locked(locked), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_rdata(rsp_rdata), .preload_q(preload_q),
  .ev_cfg_write(ev_cfg_write), .ev_deny(ev_deny)
);

// File: tb/cfgsec_ctrl_bench.sv
module cfgsec_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6, DATA_W = 8, CFG_DEPTH = 32, NUM_REG = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic rsp_valid, locked;
  logic [1:0] rsp_status;
  logic [DATA_W-1:0] rsp_rdata;
  logic [NUM_REG-1:0] preload_q;

  int n_chk = 0, n_bad = 0;
  logic [1:0] got_st;
  logic [DATA_W-1:0] got_rd;
  logic [DATA_W-1:0] exp_sig [8];
  logic [NUM_REG-1:0] exp_pre = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgsec_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_DEPTH(CFG_DEPTH), .NUM_REG(NUM_REG)) u_cfgsec_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .locked(locked),
    .preload_q(preload_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, read at the next falling edge.
  task automatic issue(input logic [2:0] op, input int a, input logic [DATA_W-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_st = rsp_status; got_rd = rsp_rdata;
    check("R2 rsp_valid", 32'(rsp_valid), 1);
  endtask

  task automatic t_reset;
    check("R1 locked", 32'(locked), 0);
    check("R1 preload_q", 32'(preload_q), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    issue(3'd2, 5, 8'h00);
    check("R1 verify status", 32'(got_st), 0);
    check("R1 verify data", 32'(got_rd), 0);
  endtask

  task automatic t_idle_nop;
    issue(3'd0, 0, 8'h5A);
    check("R2 nop status", 32'(got_st), 0);
    check("R2 nop data", 32'(got_rd), 0);
    @(negedge clk);
    check("R2 idle rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_prog_verify;
    issue(3'd1, 0, 8'hA5);  check("R3 prog status", 32'(got_st), 0);
    check("R2 write data zero", 32'(got_rd), 0);
    issue(3'd1, 31, 8'h3C); check("R3 prog status", 32'(got_st), 0);
    issue(3'd1, 7, 8'hFF);  check("R3 prog status", 32'(got_st), 0);
    issue(3'd2, 0, 8'h00);  check("R3 verify 0", 32'(got_rd), 32'hA5);
    issue(3'd2, 31, 8'h00); check("R3 verify 31", 32'(got_rd), 32'h3C);
    issue(3'd2, 7, 8'h00);  check("R3 verify 7", 32'(got_rd), 32'hFF);
    check("R3 verify status", 32'(got_st), 0);
    issue(3'd2, 1, 8'h00);  check("R3 unwritten", 32'(got_rd), 0);
    issue(3'd1, 0, 8'h12);  issue(3'd2, 0, 8'h00);
    check("R3 overwrite", 32'(got_rd), 32'h12);
  endtask

  task automatic t_bad_addr;
    issue(3'd1, 40, 8'h77); check("R4 prog range", 32'(got_st), 2);
    issue(3'd2, 40, 8'h00); check("R4 verify range", 32'(got_st), 2);
    check("R4 verify data", 32'(got_rd), 0);
    issue(3'd3, 10, 8'h01); check("R4 preload range", 32'(got_st), 2);
    check("R4 preload untouched", 32'(preload_q), 32'(exp_pre));
    issue(3'd4, 8, 8'h99);  check("R4 sig range", 32'(got_st), 2);
    issue(3'd5, 8, 8'h00);  check("R4 sig read range", 32'(got_st), 2);
    check("R4 sig read data", 32'(got_rd), 0);
    // Address 40 aliases configuration word 8 in its low bits: it must stay 0.
    issue(3'd2, 8, 8'h00);  check("R4 no alias write", 32'(got_rd), 0);
  endtask

  task automatic t_preload;
    issue(3'd3, 3, 8'h01); exp_pre[3] = 1'b1;
    check("R5 status", 32'(got_st), 0);
    check("R5 bit3", 32'(preload_q), 32'(exp_pre));
    issue(3'd3, 9, 8'hFF); exp_pre[9] = 1'b1;
    check("R5 bit9", 32'(preload_q), 32'(exp_pre));
    issue(3'd3, 3, 8'hFE); exp_pre[3] = 1'b0;
    check("R5 clear bit3 uses bit0 only", 32'(preload_q), 32'(exp_pre));
  endtask

  task automatic t_signature;
    for (int i = 0; i < 8; i++) begin
      exp_sig[i] = 8'(i * 37 + 11);
      issue(3'd4, i, exp_sig[i]);
      check("R6 sig write status", 32'(got_st), 0);
    end
    for (int i = 0; i < 8; i++) begin
      issue(3'd5, i, 8'h00);
      check("R6 sig read", 32'(got_rd), 32'(exp_sig[i]));
    end
  endtask

  task automatic t_lock;
    issue(3'd6, 0, 8'h00);
    check("R7 lock status", 32'(got_st), 0);
    check("R7 locked", 32'(locked), 1);
    issue(3'd2, 31, 8'h00);
    check("R8 verify status", 32'(got_st), 1);
    check("R8 verify zero", 32'(got_rd), 0);
    issue(3'd2, 50, 8'h00);
    check("R8 verify any addr", 32'(got_st), 1);
    issue(3'd3, 0, 8'h01);
    check("R9 preload status", 32'(got_st), 1);
    check("R9 preload frozen", 32'(preload_q), 32'(exp_pre));
    issue(3'd1, 2, 8'h44);
    check("R10 prog status", 32'(got_st), 1);
    issue(3'd6, 0, 8'h00);
    check("R7 still locked", 32'(locked), 1);
    issue(3'd5, 3, 8'h00);
    check("R6 sig read locked status", 32'(got_st), 0);
    check("R6 sig read locked data", 32'(got_rd), 32'(exp_sig[3]));
    exp_sig[6] = 8'hC3;
    issue(3'd4, 6, 8'hC3);
    check("R6 sig write locked", 32'(got_st), 0);
    issue(3'd5, 6, 8'h00);
    check("R6 sig readback locked", 32'(got_rd), 32'hC3);
  endtask

  task automatic t_erase;
    issue(3'd7, 0, 8'h00);
    check("R11 erase status", 32'(got_st), 0);
    check("R11 unlocked", 32'(locked), 0);
    issue(3'd2, 31, 8'h00); check("R11 word31 cleared", 32'(got_rd), 0);
    issue(3'd2, 7, 8'h00);  check("R11 word7 cleared", 32'(got_rd), 0);
    issue(3'd2, 2, 8'h00);  check("R10 denied write absent", 32'(got_rd), 0);
    check("R11 preload kept", 32'(preload_q), 32'(exp_pre));
    issue(3'd5, 6, 8'h00);  check("R11 sig kept", 32'(got_rd), 32'(exp_sig[6]));
    issue(3'd5, 0, 8'h00);  check("R11 sig0 kept", 32'(got_rd), 32'(exp_sig[0]));
    issue(3'd1, 4, 8'h6D);  check("R10 prog after erase", 32'(got_st), 0);
    issue(3'd2, 4, 8'h00);  check("R10 verify after erase", 32'(got_rd), 32'h6D);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_nop();
    t_prog_verify();
    t_bad_addr();
    t_preload();
    t_signature();
    t_lock();
    t_erase();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule